// File: doc/BRIEF.md
# Multiprocessor Interrupt Level Router

The router gathers 32 device interrupt lines into a master pending register and forwards the enabled ones to a single target CPU. That CPU is chosen from a power-of-two set of processors. Each device line has a processor interrupt level from 1 to 15, taken from a parameter table. An entry of 0 in that table leaves the line unrouted. Every CPU also has its own soft-interrupt register. Software can set or clear bits in it, and device assertions also set bits in it.

Each CPU receives a 15-line level vector. Line `k` of that vector is high while level `k+1` is pending from any source. Software uses a single-cycle write strobe, with a function/CPU address and 32-bit data, to do the following:
- set or clear soft interrupts;
- disable or re-enable master sources;
- pick the target CPU.

The level outputs are registered. They are recomputed from the current state on every clock, so they follow any register write or line change one cycle later.

Top module: `irq_level_router`

## Requirements
- R1: Reset state. After reset, master pending is 0, the target CPU is 0 and the disable register is 0x004DFF80. Every level output is 0.
- R2: Device line rise and fall. A rise on device line j sets master pending bit j. If j maps to level L (not 0), the rise also sets soft level L in the current target's soft register. A fall clears both. If a set and a clear hit the same level in one cycle, the set wins.
- R3: Master routing. Master pending bits that are not disabled drive their mapped levels into the target CPU's vector only. Table entry j sits at `LVL_MAP[4j+3:4j]`, and a value of 0 means bit j is unrouted.
- R4: Global disable. While bit 31 of the disable register is 1, no master source reaches any CPU.
- R5: Soft levels. Soft data bits 17..31 stand for levels 1..15. Data bit 16 and below have no effect.
- R6: Soft clear. A write with function 0 clears `wr_data[31:17]` from the addressed CPU's soft register.
- R7: Soft set. A write with function 1 sets `wr_data[31:17]` in the addressed CPU's soft register.
- R8: Master disable. A write with function 2 drops the bits of 0x4FB2007F from the data. It ORs the remaining bits into the disable register and clears the same bits from master pending.
- R9: Master enable. A write with function 3 clears the data bits from the disable register.
- R10: Target select. A write with function 4 loads the target CPU from the low log2(NUM_CPU) bits of `wr_data`.
- R11: Output timing and layout. CPU i's vector is `lvl_out[15i+14:15i]`, and bit k stands for level k+1. It reflects the state as it stood on the previous clock edge. A write or line change therefore shows on the outputs at the second rising edge after the inputs were presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dev_irq | input | 32 | Device interrupt lines, active high |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_addr | input | log2(NUM_CPU)+3 | Upper 3 bits: function 0..4; lower bits: CPU index |
| wr_data | input | 32 | Write data |
| lvl_out | output | 15*NUM_CPU | Per-CPU level vectors |

## Verification
Several internal faults show up at the ports within two clock edges of the input that exposes them:
- a corrupted disable or pending bit;
- a wrong target register;
- a stale soft bit.

Each of these either lights a level line that should be dark or leaves one dark. A behavioural model tracks the state. Every output line of every CPU is compared against it on each cycle, under both directed and random writes and line activity.

Some faults hide until later. A pending bit that is wrongly set only appears once its source is enabled. A soft bit that is wrong on a non-target CPU shows at once. Targeted sequences therefore re-enable sources and move the target, so that latent state is forced onto the outputs.

// File: rtl/irq_level_router.sv
module irq_level_router #(
  parameter int NUM_CPU = 4,
  parameter logic [127:0] LVL_MAP = 128'hFEDCBA98_76543210_0F7E9C35_0A246810,
  localparam int CW = $clog2(NUM_CPU),
  localparam int AW = CW + 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [31:0]            dev_irq,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [31:0]            wr_data,
  output logic [NUM_CPU*15-1:0]  lvl_out
);
  localparam logic [31:0] KEEP_MASK = 32'h4FB2007F;
  localparam logic [31:0] DIS_RESET = ~32'hFFB2007F;

  logic [31:0] dev_q, pend_q, dis_q, pend_n, dis_n;
  logic [CW-1:0] tgt_q, tgt_n;
  logic [NUM_CPU-1:0][14:0] soft_q, soft_n;
  logic [14:0] lv_set, lv_clr, master_lv;
  logic [31:0] wmask;

  wire [31:0]   rise = dev_irq & ~dev_q;
  wire [31:0]   fall = ~dev_irq & dev_q;
  wire [2:0]    func = wr_addr[AW-1:CW];
  wire [CW-1:0] wcpu = wr_addr[CW-1:0];
  wire [31:0]   routed = pend_q & ~dis_q;

  assign wmask = wr_data & ~KEEP_MASK;

  always_comb begin
    lv_set = '0;
    lv_clr = '0;
    master_lv = '0;
    for (int j = 0; j < 32; j++) begin
      if (LVL_MAP[4*j +: 4] != 4'd0) begin
        if (rise[j])   lv_set[LVL_MAP[4*j +: 4] - 4'd1] = 1'b1;
        if (fall[j])   lv_clr[LVL_MAP[4*j +: 4] - 4'd1] = 1'b1;
        if (routed[j]) master_lv[LVL_MAP[4*j +: 4] - 4'd1] = 1'b1;
      end
    end
    if (dis_q[31]) master_lv = '0;
  end

  always_comb begin
    pend_n = (pend_q & ~fall) | rise;
    dis_n  = dis_q;
    tgt_n  = tgt_q;
    soft_n = soft_q;
    soft_n[tgt_q] = (soft_q[tgt_q] & ~lv_clr) | lv_set;
    if (wr_en) begin
      case (func)
        3'd0: soft_n[wcpu] = soft_n[wcpu] & ~wr_data[31:17];
        3'd1: soft_n[wcpu] = soft_n[wcpu] | wr_data[31:17];
        3'd2: begin
          dis_n  = dis_q | wmask;
          pend_n = pend_n & ~wmask;
        end
        3'd3: dis_n = dis_q & ~wr_data;
        3'd4: tgt_n = wr_data[CW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dev_q  <= '0;
      pend_q <= '0;
      dis_q  <= DIS_RESET;
      tgt_q  <= '0;
      soft_q <= '0;
    end else begin
      dev_q  <= dev_irq;
      pend_q <= pend_n;
      dis_q  <= dis_n;
      tgt_q  <= tgt_n;
      soft_q <= soft_n;
    end
  end

  for (genvar i = 0; i < NUM_CPU; i++) begin : g_cpu
    always_ff @(posedge clk) begin
      if (rst) lvl_out[15*i +: 15] <= '0;
      else     lvl_out[15*i +: 15] <= soft_q[i] | ((tgt_q == CW'(i)) ? master_lv : 15'd0);
    end
  end
endmodule

module irq_level_router_chk #(
  parameter int NUM_CPU = 4,
  localparam int CW = $clog2(NUM_CPU),
  localparam int AW = CW + 3
) (
  input logic                  clk,
  input logic                  rst,
  input logic [31:0]           dev_irq,
  input logic [31:0]           dev_q,
  input logic                  wr_en,
  input logic [AW-1:0]         wr_addr,
  input logic [31:0]           wr_data,
  input logic [31:0]           pend_q,
  input logic [31:0]           dis_q,
  input logic [CW-1:0]         tgt_q,
  input logic [NUM_CPU-1:0][14:0] soft_q,
  input logic [NUM_CPU*15-1:0] lvl_out
);
  wire [31:0] c_rise = dev_irq & ~dev_q;
  wire [2:0]  c_func = wr_addr[AW-1:CW];
  wire [31:0] c_dmask = wr_data & ~32'h4FB2007F;

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (pend_q == 32'd0 && tgt_q == '0 && dis_q == 32'h004DFF80 && lvl_out == '0)); // R1

  AST_RISE_PENDS: assert property (@(posedge clk) disable iff (rst)
    (c_rise != 0 && !(wr_en && c_func == 3'd2)) |=> ((pend_q & $past(c_rise)) == $past(c_rise))); // R2

  AST_GLOBAL_OFF: assert property (@(posedge clk) disable iff (rst)
    (dis_q[31] && soft_q == '0) |=> (lvl_out == '0)); // R4

  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (wr_en && c_func == 3'd0 && c_rise == 0) |=> ((soft_q[$past(wr_addr[CW-1:0])] & $past(wr_data[31:17])) == 15'd0)); // R6

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && c_func == 3'd2 && c_rise == 0) |=> ((pend_q & $past(c_dmask)) == 32'd0 && (dis_q & $past(c_dmask)) == $past(c_dmask))); // R8

  AST_TARGET_LOW: assert property (@(posedge clk) disable iff (rst)
    (wr_en && c_func == 3'd4) |=> (tgt_q == $past(wr_data[CW-1:0]))); // R10
endmodule

bind irq_level_router irq_level_router_chk #(.NUM_CPU(NUM_CPU)) u_chk (
  .clk(clk), .rst(rst), .dev_irq(dev_irq), .dev_q(dev_q), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data), .pend_q(pend_q), .dis_q(dis_q),
  .tgt_q(tgt_q), .soft_q(soft_q), .lvl_out(lvl_out)
);

// File: tb/sim_irq_level_router.sv
`timescale 1ns/1ps
module sim_irq_level_router;
  localparam int NUM_CPU = 4;
  localparam int CW = 2;
  localparam logic [127:0] MAP = 128'hFEDCBA98_76543210_0F7E9C35_0A246810;

  logic clk = 0, rst = 1, wr_en = 0;
  logic [31:0] dev_irq = 0, wr_data = 0;
  logic [CW+2:0] wr_addr = 0;
  logic [NUM_CPU*15-1:0] lvl_out;
  int checks = 0, fails = 0;
  string tag = "R1";
  bit done = 0;

  always #4 clk = ~clk;

  irq_level_router #(.NUM_CPU(NUM_CPU), .LVL_MAP(MAP)) u0 (
    .clk(clk), .rst(rst), .dev_irq(dev_irq), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .lvl_out(lvl_out));

  // behavioural reference
  bit [31:0] m_pend, m_dis, m_prev;
  int m_tgt;
  bit [14:0] m_soft [NUM_CPU];
  bit [NUM_CPU*15-1:0] m_out;

  function automatic int lvl_of(int j);
    return int'(MAP[4*j +: 4]);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_pend = 0; m_dis = 32'h004DFF80; m_prev = 0; m_tgt = 0; m_out = 0;
      foreach (m_soft[i]) m_soft[i] = 0;
    end else begin
      bit [14:0] mlv, sset, sclr;
      bit [31:0] dm;
      int f, c;
      mlv = 0; sset = 0; sclr = 0;
      if (!m_dis[31])
        for (int j = 0; j < 32; j++)
          if (m_pend[j] && !m_dis[j] && lvl_of(j) > 0) mlv[lvl_of(j)-1] = 1;
      for (int i = 0; i < NUM_CPU; i++)
        m_out[15*i +: 15] = m_soft[i] | ((i == m_tgt) ? mlv : 15'd0);
      for (int j = 0; j < 32; j++) begin
        if (dev_irq[j] && !m_prev[j]) begin
          m_pend[j] = 1;
          if (lvl_of(j) > 0) sset[lvl_of(j)-1] = 1;
        end
        if (!dev_irq[j] && m_prev[j]) begin
          m_pend[j] = 0;
          if (lvl_of(j) > 0) sclr[lvl_of(j)-1] = 1;
        end
      end
      c = m_tgt;
      m_soft[c] = (m_soft[c] & ~sclr) | sset;
      if (wr_en) begin
        f = int'(wr_addr[CW+2:CW]);
        c = int'(wr_addr[CW-1:0]);
        dm = wr_data & ~32'h4FB2007F;
        case (f)
          0: m_soft[c] = m_soft[c] & ~wr_data[31:17];
          1: m_soft[c] = m_soft[c] | wr_data[31:17];
          2: begin m_dis = m_dis | dm; m_pend = m_pend & ~dm; end
          3: m_dis = m_dis & ~wr_data;
          4: m_tgt = int'(wr_data[CW-1:0]);
          default: ;
        endcase
      end
      m_prev = dev_irq;
    end
  end

  task automatic chk(string r, logic [NUM_CPU*15-1:0] act, logic [NUM_CPU*15-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: lvl_out=%h expected %h", r, act, exp);
    end
  endtask

  always @(negedge clk) if (!rst && !done) chk(tag, lvl_out, m_out);

  task automatic wr(int f, int c, logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = {3'(f), CW'(c)}; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  function automatic logic [14:0] cpu(int i);
    return lvl_out[15*i +: 15];
  endfunction

  task automatic lit(string r, int i, logic [14:0] exp);
    checks++;
    if (cpu(i) !== exp) begin
      fails++;
      $display("FAIL %s: cpu%0d=%h expected %h", r, i, cpu(i), exp);
    end
  endtask

  initial begin
    #(8ns * 100000);
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    for (int i = 0; i < NUM_CPU; i++) lit("R1", i, 15'h0);

    tag = "R5";
    wr(1, 1, 32'h8003_0000);           // bits 31,17,16
    @(negedge clk); lit("R5", 1, 15'h4001);
    tag = "R6";
    wr(0, 1, 32'h8001_0000);
    @(negedge clk); lit("R6", 1, 15'h0001);
    wr(0, 1, 32'hFFFF_FFFF);
    @(negedge clk); lit("R6", 1, 15'h0);

    tag = "R11";
    wr(1, 3, 32'h0004_0000);           // level 2 on cpu3
    lit("R11", 3, 15'h0);              // not yet visible
    @(negedge clk); lit("R11", 3, 15'h0002);
    wr(0, 3, 32'hFFFE_0000);

    tag = "R2";
    @(negedge clk) dev_irq = 32'h0000_0004; // line 2 -> level 8
    @(negedge clk); @(negedge clk); lit("R2", 0, 15'h0080);
    tag = "R3";
    wr(0, 0, 32'hFFFE_0000);           // clear soft; master path remains
    @(negedge clk); lit("R3", 0, 15'h0080);
    tag = "R10";
    wr(4, 0, 32'hFFFF_FFF6);           // low bits 2
    @(negedge clk); lit("R10", 2, 15'h0080); lit("R10", 0, 15'h0);
    tag = "R4";
    wr(2, 0, 32'h8000_0000);
    @(negedge clk); lit("R4", 2, 15'h0);
    tag = "R9";
    wr(3, 0, 32'h8000_0000);
    @(negedge clk); lit("R9", 2, 15'h0080);
    tag = "R8";
    wr(2, 0, 32'h4000_0004);           // both bits in keep mask: ignored
    @(negedge clk); lit("R8", 2, 15'h0080);
    tag = "R2";
    @(negedge clk) dev_irq = 32'h0;
    @(negedge clk); @(negedge clk); lit("R2", 2, 15'h0);
    tag = "R3";
    @(negedge clk) dev_irq = 32'h0000_0001; // unrouted line
    @(negedge clk); @(negedge clk);
    for (int i = 0; i < NUM_CPU; i++) lit("R3", i, 15'h0);
    tag = "R8";
    @(negedge clk) dev_irq = 32'h0000_0003; // line 1 -> level 1
    @(negedge clk); wr(0, 2, 32'hFFFE_0000);
    @(negedge clk); lit("R8", 2, 15'h0001);
    wr(2, 0, 32'h0000_0100);           // bit 8 allowed through
    wr(2, 0, 32'h0000_0002);           // bit 1 in keep mask: ignored
    @(negedge clk); lit("R8", 2, 15'h0001);
    wr(3, 0, 32'hFFFF_FFFF);
    wr(2, 0, 32'h0000_0800);           // disable line 11
    @(negedge clk); lit("R8", 2, 15'h0001);

    tag = "R7";
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      if ($urandom_range(3) == 0) dev_irq = $urandom;
      if ($urandom_range(1) == 0) begin
        wr_en = 1;
        wr_addr = {3'($urandom_range(4)), CW'($urandom_range(NUM_CPU-1))};
        wr_data = $urandom;
      end else wr_en = 0;
    end
    @(negedge clk) wr_en = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule